// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block controls one differential clock output pair while the output is put into and taken out of a power-saving state. A free-running system clock advances an internal phase bit; the true leg follows the phase and the complement leg is its inverse. Each leg has its own output-enable, and a power-save flag tells the upstream clock source that it may stop.

An active-low, asynchronous power-down request is resynchronised through two flops. The request counts only when it is sampled low on two consecutive rising edges of the complement leg. Once counted, the pair is parked on the next falling edge of the complement leg, so the last complement pulse keeps its full width. A configuration bit selects the parked form. In one form the true leg is held high and driven while the complement leg floats. In the other form both legs float. The power-save flag rises only after the park has taken effect.

On release the flag drops at once. In the fully floating form both legs are driven to a static high/low level straight away, well inside the short drive bound. Clocking resumes only when the lock indication is high. It resumes on a complement-low phase, so the first pulse is full width. A tick-driven counter raises a timeout flag if lock does not arrive within a set number of timebase ticks. A polarity input inverts the sense of both enable pins.

Top module: `clkout_pd_seq`

## Requirements
- R1: After reset the block runs: both enable pins report enabled, power-save and timeout are low, and the true and complement legs toggle every cycle in opposite phase.
- R2: A request that is sampled low on at most one complement rising edge does not park the outputs; two consecutive low samples are needed.
- R3: Parking happens on a falling edge of the complement leg. The complement leg is high for one full cycle just before the park, and low in the cycle before that.
- R4: With the park-mode bit at 0, the parked pair has the true leg high and enabled and the complement leg disabled.
- R5: With the park-mode bit at 1, the parked pair has both legs disabled.
- R6: Power-save goes high exactly one cycle after the outputs park and stays high until release.
- R7: After release, power-save drops on the third clock edge, because of the two-flop resynchroniser. The pair stays parked while lock is low. The first cycle after lock shows true high and complement low with both legs enabled, and the legs then toggle.
- R8: With the park-mode bit at 1, both legs are enabled from the moment power-save drops on release, at true high and complement low, before lock arrives.
- R9: The timeout flag rises if lock is not seen within LOCK_TICKS timebase ticks after release. It is low during the wait before that and low again once clocking resumes.
- R10: With the polarity input at 0, an enable pin at 1 means the leg is driven. With it at 1, an enable pin at 0 means driven. The park sequencing is otherwise the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| park_float | input | 1 | Park form: 0 true-high driven, 1 both legs floating |
| oe_inv | input | 1 | Inverts the sense of both enable pins |
| lock_ok | input | 1 | Clock source stable indication |
| tick | input | 1 | Slow timebase strobe, one cycle wide |
| dif_t | output | 1 | True leg value |
| dif_c | output | 1 | Complement leg value |
| oe_t | output | 1 | True leg enable (sense set by oe_inv) |
| oe_c | output | 1 | Complement leg enable (sense set by oe_inv) |
| pwr_save | output | 1 | Clock source may stop |
| lock_tmo | output | 1 | Lock not seen within LOCK_TICKS ticks |

## Verification
The park-form checks assume that park_float and oe_inv do not change while the pair is parked or waking. The bench changes them only while clocks run. The lock-gating check assumes that lock_ok is a level signal held through resume. The bench raises lock_ok only after release and drops it only after clocking has restarted. The two-sample check assumes that the request passes through the resynchroniser unchanged. The bench drives pd_req_n on falling clock edges, so the flops never see it change at the sampling edge.

// File: rtl/clkout_pd_seq.sv
module clkout_pd_seq #(
  parameter int LOCK_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req_n,
  input  logic park_float,
  input  logic oe_inv,
  input  logic lock_ok,
  input  logic tick,
  output logic dif_t,
  output logic dif_c,
  output logic oe_t,
  output logic oe_c,
  output logic pwr_save,
  output logic lock_tmo
);
  localparam int CW = $clog2(LOCK_TICKS + 1);
  localparam logic [CW-1:0] TMAX = CW'(LOCK_TICKS);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_PARK = 2'd1, S_SAVE = 2'd2, S_WAKE = 2'd3} st_t;

  st_t st;
  logic [1:0] sync;
  logic ph;
  logic [1:0] lowcnt;
  logic [CW-1:0] wcnt;

  wire req_s = sync[1];
  wire run = (st == S_RUN);
  wire wake = (st == S_WAKE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], pd_req_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      ph     <= 1'b0;
      lowcnt <= 2'd0;
      wcnt   <= '0;
    end else begin
      case (st)
        S_RUN: begin
          ph <= ~ph;
          if (ph) begin
            if (req_s)              lowcnt <= 2'd0;
            else if (lowcnt != 2'd2) lowcnt <= lowcnt + 2'd1;
          end else if (lowcnt == 2'd2) begin
            st <= S_PARK;
          end
        end
        S_PARK: begin
          st     <= S_SAVE;
          lowcnt <= 2'd0;
          ph     <= 1'b1;
        end
        S_SAVE: begin
          wcnt <= '0;
          if (req_s) st <= S_WAKE;
        end
        S_WAKE: begin
          if (tick && wcnt != TMAX) wcnt <= wcnt + 1'b1;
          if (!req_s) st <= S_SAVE;
          else if (lock_ok) begin
            st <= S_RUN;
            ph <= 1'b1;
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  wire en_t = run | wake | !park_float;
  wire en_c = run | (wake & park_float);

  assign dif_t    = run ? ph : 1'b1;
  assign dif_c    = run ? ~ph : 1'b0;
  assign oe_t     = en_t ^ oe_inv;
  assign oe_c     = en_c ^ oe_inv;
  assign pwr_save = (st == S_SAVE);
  assign lock_tmo = wake && (wcnt == TMAX);
endmodule

// File: rtl/clkout_pd_seq_chk.sv
module clkout_pd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_s,
  input logic [1:0] st,
  input logic       dif_t,
  input logic       dif_c,
  input logic       oe_t,
  input logic       oe_c,
  input logic       oe_inv,
  input logic       park_float,
  input logic       pwr_save,
  input logic       lock_tmo,
  input logic       lock_ok
);
  wire drv_t = oe_t ^ oe_inv;
  wire drv_c = oe_c ^ oe_inv;

  AST_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && $past(st) != 2'd1) |-> (!$past(req_s, 2) && !$past(req_s, 4))); // R2
  AST_FULL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && $past(st) != 2'd1) |-> ($past(dif_c) && !$past(dif_c, 2))); // R3
  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_save && !park_float) |-> (dif_t && drv_t && !drv_c)); // R4
  AST_BOTH_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_save && park_float) |-> (!drv_t && !drv_c)); // R5
  AST_PARK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_save) |-> ($past(st) == 2'd1)); // R6
  AST_LOCK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && $past(st) == 2'd3) |-> $past(lock_ok)); // R7
  AST_WAKE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && park_float) |-> (drv_t && drv_c && dif_t && !dif_c)); // R8
  AST_TMO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_tmo |-> (st == 2'd3)); // R9
endmodule

bind clkout_pd_seq clkout_pd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_s(req_s), .st(st),
  .dif_t(dif_t), .dif_c(dif_c), .oe_t(oe_t), .oe_c(oe_c),
  .oe_inv(oe_inv), .park_float(park_float), .pwr_save(pwr_save),
  .lock_tmo(lock_tmo), .lock_ok(lock_ok)
);

// File: tb/clkout_pd_seq_tb.sv
module clkout_pd_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0, pd_req_n = 1'b1, park_float = 1'b0;
  logic oe_inv = 1'b0, lock_ok = 1'b0, tick = 1'b0;
  logic dif_t, dif_c, oe_t, oe_c, pwr_save, lock_tmo;
  int n_chk = 0, n_bad = 0;
  int tcnt = 0;

  clkout_pd_seq #(.LOCK_TICKS(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .park_float(park_float),
    .oe_inv(oe_inv), .lock_ok(lock_ok), .tick(tick), .dif_t(dif_t), .dif_c(dif_c),
    .oe_t(oe_t), .oe_c(oe_c), .pwr_save(pwr_save), .lock_tmo(lock_tmo)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    tick <= (tcnt == 3);
  end

  function automatic logic dt(); return oe_t ^ oe_inv; endfunction
  function automatic logic dc(); return oe_c ^ oe_inv; endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    logic pt;
    @(negedge clk);
    check(dt() && dc(), "R1 enables", {dt(), dc()}, 3);
    check(!pwr_save && !lock_tmo, "R1 flags", {pwr_save, lock_tmo}, 0);
    pt = dif_t;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(dif_t != pt && dif_c == !dif_t, "R1 toggle", {dif_t, dif_c}, {!pt, pt});
      pt = dif_t;
    end
  endtask

  task automatic t_glitch();
    logic pt;
    int bad = 0;
    @(negedge clk); pd_req_n = 1'b0;
    @(negedge clk);
    @(negedge clk); pd_req_n = 1'b1;
    pt = dif_t;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwr_save || dif_t == pt || !dc()) bad++;
      pt = dif_t;
    end
    check(bad == 0, "R2 short request ignored", bad, 0);
  endtask

  task automatic t_enter(input logic mode);
    logic pc = 1'b0, ppc = 1'b0;
    logic found = 1'b0;
    park_float = mode;
    @(negedge clk); pd_req_n = 1'b0;
    for (int i = 0; i < 30 && !found; i++) begin
      @(negedge clk);
      if (!dc()) begin
        found = 1'b1;
        check(pc && !ppc, "R3 full last pulse", {ppc, pc}, 1);
        check(dif_t && !pwr_save, "R6 park before save", {dif_t, pwr_save}, 2);
      end else begin
        ppc = pc; pc = dif_c;
      end
    end
    check(found, "R3 park seen", found, 1);
    @(negedge clk);
    check(pwr_save, "R6 save one cycle after park", pwr_save, 1);
    if (!mode) check(dif_t && dt() && !dc(), "R4 true high driven", {dif_t, dt(), dc()}, 6);
    else       check(!dt() && !dc(), "R5 both floating", {dt(), dc()}, 0);
    repeat (3) @(negedge clk);
    check(pwr_save, "R6 save held", pwr_save, 1);
  endtask

  task automatic t_release(input logic mode, input int waitc, input logic want_tmo);
    int n = 0;
    @(negedge clk); pd_req_n = 1'b1;
    while (pwr_save && n < 10) begin @(negedge clk); n++; end
    check(n == 3, "R7 release latency", n, 3);
    if (mode) check(dt() && dc() && dif_t && !dif_c, "R8 driven on release", {dt(), dc(), dif_t, dif_c}, 14);
    else      check(dt() && !dc() && dif_t, "R7 parked while unlocked", {dt(), dc(), dif_t}, 5);
    check(!lock_tmo, "R9 no early timeout", lock_tmo, 0);
    repeat (waitc) @(negedge clk);
    check(dif_t && !dif_c && !pwr_save, "R7 no clock without lock", {dif_t, dif_c}, 2);
    check(lock_tmo == want_tmo, "R9 timeout flag", lock_tmo, want_tmo);
    lock_ok = 1'b1;
    @(negedge clk);
    check(dif_t && !dif_c && dt() && dc(), "R7 first resume phase", {dif_t, dif_c, dt(), dc()}, 11);
    check(!lock_tmo, "R9 timeout clears", lock_tmo, 0);
    @(negedge clk);
    check(!dif_t && dif_c, "R7 toggles after lock", {dif_t, dif_c}, 1);
    lock_ok = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_invert();
    @(negedge clk); oe_inv = 1'b1;
    @(negedge clk);
    check(oe_t == 1'b0 && oe_c == 1'b0, "R10 inverted enables running", {oe_t, oe_c}, 0);
    t_enter(1'b1);
    check(oe_t && oe_c, "R10 inverted float pins", {oe_t, oe_c}, 3);
    t_release(1'b1, 4, 1'b0);
    oe_inv = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_glitch();
    t_enter(1'b0);
    t_release(1'b0, 4, 1'b0);
    t_enter(1'b1);
    t_release(1'b1, 6, 1'b0);
    t_enter(1'b0);
    t_release(1'b0, 40, 1'b1);
    t_invert();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule